// File: doc/BRIEF.md
# Masked CAM Lookup Engine

This block keeps a small table of 64-bit entries and serves commands that arrive through a control port. Software loads a 64-bit operand into four 16-bit I/O registers. The lowest register supplies bits 15:0 and the highest supplies bits 63:48. It then issues a command that inserts the operand into the table, looks it up, deletes a matching entry, loads it as the global compare mask, or re-initializes the table.

Lookups use a masked equality compare. A mask bit set to 1 removes that key bit from the comparison, and only valid slots take part. When a check finds a hit, the stored entry is written back into the I/O registers and the last-match flag is raised. Every accepted command takes the same fixed number of cycles. During that time the block shows busy and drops any further register or command writes.

If the mask is changed while the table holds entries, the table is marked uninitialized. Lookups then find nothing until an initialize command is run.

Top module: `cam_lookup_engine`

## Requirements
- R1: After reset: busy_o=0, match_ok_o=0, tbl_init_o=1, irq_o=0, io_rd_o=0, no valid slot, and the mask is all zeros.
- R2: A write with io_we_i=1 while idle loads io_wdata_i into I/O register io_sel_i. io_rd_o is {reg3,reg2,reg1,reg0}, so bit 15 of reg3 is bit 63 and bit 0 of reg0 is bit 0. The compare key is this same 64-bit value.
- R3: A command write with cmd_op_i in 1..5 (1 check, 2 delete, 3 set mask, 4 insert, 5 initialize) is accepted while idle. busy_o is then high for exactly LAT=8 cycles, and the results appear on the edge where busy_o falls. Codes 0, 6 and 7 are ignored and do not raise busy_o.
- R4: While busy_o=1, I/O register writes and command writes are ignored. They are not queued either.
- R5: Set mask (3) copies the 64-bit I/O value into the mask. A mask bit of 1 excludes that key bit from every compare, and a 0 includes it.
- R6: Check (1) with a hit sets match_ok_o=1 and writes the stored entry into the four I/O registers.
- R7: Check with no hit clears match_ok_o and leaves the I/O registers unchanged.
- R8: irq_o pulses high for one cycle at the completion of a check when check_irq_en_i=1, whether or not the check hits. No other command raises it.
- R9: Insert (4) stores the I/O value in the lowest-numbered invalid slot. When every slot is valid the insert has no effect.
- R10: Delete (2) invalidates the slot that the masked compare hits and leaves match_ok_o unchanged. Invalid slots never match.
- R11: Set mask while at least one slot is valid clears tbl_init_o, and on an empty table it leaves the flag set. Initialize (5) sets tbl_init_o. While tbl_init_o=0, check and delete find nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_we_i | input | 1 | I/O register write strobe |
| io_sel_i | input | 2 | I/O register select |
| io_wdata_i | input | 16 | I/O register write data |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_op_i | input | 3 | Command code |
| check_irq_en_i | input | 1 | Enables the completion interrupt for check |
| io_rd_o | output | 64 | Concatenated I/O registers |
| busy_o | output | 1 | Command in progress |
| match_ok_o | output | 1 | Last check hit |
| tbl_init_o | output | 1 | Table initialized |
| irq_o | output | 1 | One-cycle check completion interrupt |

## Verification
The case that is hardest to reach from the ports is a hit that depends on exactly one mask bit. The stored entries must then differ from the key in that bit and nowhere else that is compared. To get there, the bench fills the table with entries that differ pairwise in at least two bits. For each of the 64 positions it sets a single-bit mask, re-initializes, and probes with a key that has that bit flipped. It then clears the mask and repeats the probe, which must now miss. Commands sent in the middle of a busy window and deletes issued while the table is uninitialized are driven at chosen negative edges.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_CHECK    = 3'd1,
    OP_DELETE   = 3'd2,
    OP_SET_MASK = 3'd3,
    OP_INSERT   = 3'd4,
    OP_INIT     = 3'd5
  } cam_op_e;
endpackage

// File: rtl/cam_io_regs.sv
module cam_io_regs #(
  parameter int IO_W   = 16,
  parameter int NUM_IO = 4,
  localparam int SEL_W = $clog2(NUM_IO),
  localparam int KEY_W = IO_W * NUM_IO
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [IO_W-1:0]  wdata_i,
  input  logic             busy_i,
  input  logic             wb_i,
  input  logic [KEY_W-1:0] wb_data_i,
  output logic [KEY_W-1:0] key_o
);
  for (genvar g = 0; g < NUM_IO; g++) begin : g_reg
    logic [IO_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) r_q <= '0;
      else if (wb_i) r_q <= wb_data_i[g*IO_W +: IO_W];
      else if (we_i && !busy_i && sel_i == SEL_W'(g)) r_q <= wdata_i;
    end
    assign key_o[g*IO_W +: IO_W] = r_q;
  end

  a_r4_io_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !wb_i |=> $stable(key_o));
endmodule

// File: rtl/cam_table.sv
module cam_table #(
  parameter int DEPTH = 16,
  parameter int KEY_W = 64,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [KEY_W-1:0] key_i,
  input  logic [KEY_W-1:0] mask_i,
  input  logic             ins_i,
  input  logic             del_i,
  output logic             hit_o,
  output logic [KEY_W-1:0] hit_data_o,
  output logic             any_valid_o
);
  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] match;
  logic [KEY_W-1:0] slot_data [DEPTH];
  logic [IW-1:0]    hit_idx, free_idx;
  logic             full;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic             v_q;
    logic [KEY_W-1:0] d_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (ins_i && !full && free_idx == IW'(g)) begin
        v_q <= 1'b1;
        d_q <= key_i;
      end else if (del_i && hit_o && hit_idx == IW'(g)) begin
        v_q <= 1'b0;
      end
    end
    assign valid_q[g]   = v_q;
    assign slot_data[g] = d_q;
    // mask bit 1 = don't care
    assign match[g] = v_q && (((d_q ^ key_i) & ~mask_i) == '0);
  end

  always_comb begin
    hit_o   = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!hit_o && match[i]) begin
        hit_o   = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  always_comb begin
    full     = 1'b1;
    free_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (full && !valid_q[i]) begin
        full     = 1'b0;
        free_idx = IW'(i);
      end
    end
  end

  assign hit_data_o  = slot_data[hit_idx];
  assign any_valid_o = |valid_q;

  a_r9_insert_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i && !(&valid_q) |=> $countones(valid_q) == $past($countones(valid_q)) + 1);
  a_r9_insert_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i && (&valid_q) |=> $stable(valid_q));
  a_r10_delete_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    del_i && hit_o |=> $countones(valid_q) == $past($countones(valid_q)) - 1);
endmodule

// File: rtl/cam_ctrl.sv
module cam_ctrl
  import cam_pkg::*;
#(
  parameter int LAT = 8,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_we_i,
  input  logic [2:0] cmd_op_i,
  input  logic       hit_i,
  input  logic       any_valid_i,
  input  logic       check_irq_en_i,
  output logic       busy_o,
  output logic       wb_o,
  output logic       ins_o,
  output logic       del_o,
  output logic       mask_we_o,
  output logic       match_ok_o,
  output logic       tbl_init_o,
  output logic       irq_o
);
  logic [CW-1:0] cnt_q;
  cam_op_e       op_q;
  logic          legal, accept, done;

  assign legal  = (cmd_op_i >= OP_CHECK) && (cmd_op_i <= OP_INIT);
  assign busy_o = cnt_q != '0;
  assign accept = cmd_we_i && !busy_o && legal;
  assign done   = cnt_q == CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      op_q  <= OP_NOP;
    end else if (accept) begin
      cnt_q <= CW'(LAT);
      op_q  <= cam_op_e'(cmd_op_i);
    end else if (busy_o) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // commit strobes, all on the last busy cycle
  assign wb_o      = done && op_q == OP_CHECK && tbl_init_o && hit_i;
  assign del_o     = done && op_q == OP_DELETE && tbl_init_o;
  assign ins_o     = done && op_q == OP_INSERT;
  assign mask_we_o = done && op_q == OP_SET_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_ok_o <= 1'b0;
      tbl_init_o <= 1'b1;
      irq_o      <= 1'b0;
    end else begin
      irq_o <= done && op_q == OP_CHECK && check_irq_en_i;
      if (done && op_q == OP_CHECK) match_ok_o <= tbl_init_o && hit_i;
      if (mask_we_o && any_valid_i) tbl_init_o <= 1'b0;
      else if (done && op_q == OP_INIT) tbl_init_o <= 1'b1;
    end
  end

  a_r3_busy_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !busy_o);
  a_r7_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable(match_ok_o));
  a_r8_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !busy_o && $past(op_q == OP_CHECK));
  a_r11_init_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tbl_init_o) |-> $past(op_q == OP_SET_MASK));
endmodule

// File: rtl/cam_lookup_engine.sv
module cam_lookup_engine #(
  parameter int DEPTH  = 16,
  parameter int LAT    = 8,
  parameter int IO_W   = 16,
  parameter int NUM_IO = 4,
  localparam int SEL_W = $clog2(NUM_IO),
  localparam int KEY_W = IO_W * NUM_IO
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             io_we_i,
  input  logic [SEL_W-1:0] io_sel_i,
  input  logic [IO_W-1:0]  io_wdata_i,
  input  logic             cmd_we_i,
  input  logic [2:0]       cmd_op_i,
  input  logic             check_irq_en_i,
  output logic [KEY_W-1:0] io_rd_o,
  output logic             busy_o,
  output logic             match_ok_o,
  output logic             tbl_init_o,
  output logic             irq_o
);
  logic [KEY_W-1:0] mask_q, hit_data;
  logic             hit, any_valid, wb, ins, del, mask_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (mask_we) mask_q <= io_rd_o;
  end

  cam_io_regs #(.IO_W(IO_W), .NUM_IO(NUM_IO)) u_io (
    .clk_i, .rst_ni,
    .we_i(io_we_i), .sel_i(io_sel_i), .wdata_i(io_wdata_i),
    .busy_i(busy_o), .wb_i(wb), .wb_data_i(hit_data),
    .key_o(io_rd_o)
  );

  cam_table #(.DEPTH(DEPTH), .KEY_W(KEY_W)) u_tbl (
    .clk_i, .rst_ni,
    .key_i(io_rd_o), .mask_i(mask_q),
    .ins_i(ins), .del_i(del),
    .hit_o(hit), .hit_data_o(hit_data), .any_valid_o(any_valid)
  );

  cam_ctrl #(.LAT(LAT)) u_ctrl (
    .clk_i, .rst_ni,
    .cmd_we_i, .cmd_op_i,
    .hit_i(hit), .any_valid_i(any_valid), .check_irq_en_i,
    .busy_o, .wb_o(wb), .ins_o(ins), .del_o(del), .mask_we_o(mask_we),
    .match_ok_o, .tbl_init_o, .irq_o
  );

  a_r5_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we |=> $stable(mask_q));
endmodule

// File: tb/tb_cam_lookup_engine.sv
`timescale 1ns/1ps
module tb_cam_lookup_engine;
  import cam_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_we = 1'b0;
  logic [1:0]  io_sel = '0;
  logic [15:0] io_wdata = '0;
  logic        cmd_we = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic        irq_en = 1'b1;
  logic [63:0] io_rd;
  logic        busy, match_ok, tbl_init, irq;

  int checks = 0;
  int fails  = 0;
  int last_n;
  logic last_irq;

  always #10 clk = ~clk;

  cam_lookup_engine dut (
    .clk_i(clk), .rst_ni(rst_n),
    .io_we_i(io_we), .io_sel_i(io_sel), .io_wdata_i(io_wdata),
    .cmd_we_i(cmd_we), .cmd_op_i(cmd_op), .check_irq_en_i(irq_en),
    .io_rd_o(io_rd), .busy_o(busy), .match_ok_o(match_ok),
    .tbl_init_o(tbl_init), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int i);
    return {16'hC0DE, 16'(i), 16'h5A5A, 16'(4096 + i)};
  endfunction

  task automatic set_key(input logic [63:0] k);
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      io_we = 1'b1; io_sel = 2'(s); io_wdata = k[s*16 +: 16];
    end
    @(negedge clk);
    io_we = 1'b0;
  endtask

  task automatic run(input cam_op_e op);
    @(negedge clk);
    cmd_we = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_we = 1'b0;
    last_n = 0;
    while (busy && last_n < 20) begin
      last_n++;
      @(negedge clk);
    end
    last_irq = irq;
  endtask

  task automatic check_key(input logic [63:0] k, input bit exp_hit, input string req);
    set_key(k);
    run(OP_CHECK);
    chk(match_ok == exp_hit, req, 64'(match_ok), 64'(exp_hit));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy, "R1 busy", 64'(busy), 64'd0);
    chk(!match_ok, "R1 match", 64'(match_ok), 64'd0);
    chk(tbl_init, "R1 init", 64'(tbl_init), 64'd1);
    chk(!irq, "R1 irq", 64'(irq), 64'd0);
    chk(io_rd == 64'd0, "R1 io", io_rd, 64'd0);

    // R10 invalid slots never match (stored data is zero after reset, key zero)
    run(OP_CHECK);
    chk(!match_ok, "R10 empty miss", 64'(match_ok), 64'd0);
    chk(last_n == 8, "R3 latency", 64'(last_n), 64'd8);
    chk(last_irq, "R8 irq on miss", 64'(last_irq), 64'd1);
    @(negedge clk);
    chk(!irq, "R8 one cycle", 64'(irq), 64'd0);

    // R11 mask change on empty table keeps init
    run(OP_SET_MASK);
    chk(tbl_init, "R11 empty mask", 64'(tbl_init), 64'd1);

    // R2 register order
    set_key(64'h8001_1234_0F0F_A5C3);
    chk(io_rd == 64'h8001_1234_0F0F_A5C3, "R2 concat", io_rd, 64'h8001_1234_0F0F_A5C3);

    // R3 undefined codes ignored
    for (int c = 0; c < 8; c++) begin
      if (c >= 1 && c <= 5) continue;
      @(negedge clk);
      cmd_we = 1'b1; cmd_op = 3'(c);
      @(negedge clk);
      cmd_we = 1'b0;
      chk(!busy, "R3 bad op", 64'(busy), 64'd0);
    end

    // R9 fill table
    for (int i = 0; i < 16; i++) begin
      set_key(pat(i));
      run(OP_INSERT);
      chk(last_n == 8, "R3 insert latency", 64'(last_n), 64'd8);
      chk(!last_irq, "R8 no irq insert", 64'(last_irq), 64'd0);
    end
    set_key(pat(99));
    run(OP_INSERT);
    check_key(pat(99), 1'b0, "R9 full insert dropped");
    check_key(pat(0), 1'b1, "R9 slot0 kept");

    // R6 hit sweep
    for (int i = 0; i < 16; i++) begin
      check_key(pat(i), 1'b1, "R6 hit");
      chk(io_rd == pat(i), "R6 io", io_rd, pat(i));
      chk(last_irq, "R8 irq hit", 64'(last_irq), 64'd1);
    end

    // R11 mask change with entries, then R6 writeback through mask
    set_key(64'h0000_0000_0000_FFFF);
    run(OP_SET_MASK);
    chk(!tbl_init, "R11 init dropped", 64'(tbl_init), 64'd0);
    check_key(pat(5), 1'b0, "R11 uninit check");
    run(OP_INIT);
    chk(tbl_init, "R11 init set", 64'(tbl_init), 64'd1);
    k = {pat(5)[63:16], 16'hDEAD};
    check_key(k, 1'b1, "R5 masked hit");
    chk(io_rd == pat(5), "R6 writeback", io_rd, pat(5));

    // R7 miss, irq disabled
    irq_en = 1'b0;
    k = 64'h0123_4567_89AB_CDEF;
    check_key(k, 1'b0, "R7 miss");
    chk(io_rd == k, "R7 io kept", io_rd, k);
    chk(!last_irq, "R8 irq disabled", 64'(last_irq), 64'd0);
    irq_en = 1'b1;

    // R5 per-bit mask sweep
    for (int b = 0; b < 64; b++) begin
      k = pat(7) ^ (64'd1 << b);
      set_key(64'd1 << b);
      run(OP_SET_MASK);
      run(OP_INIT);
      check_key(k, 1'b1, "R5 bit ignored");
      set_key(64'd0);
      run(OP_SET_MASK);
      run(OP_INIT);
      check_key(k, 1'b0, "R5 bit compared");
    end

    // R4 writes during busy ignored
    k = 64'h7777_0000_7777_0000;
    set_key(k);
    @(negedge clk);
    cmd_we = 1'b1; cmd_op = OP_CHECK;
    @(negedge clk);
    cmd_we = 1'b1; cmd_op = OP_SET_MASK;
    io_we = 1'b1; io_sel = 2'd0; io_wdata = 16'hBEEF;
    last_n = 1;
    @(negedge clk);
    cmd_we = 1'b0; io_we = 1'b0;
    while (busy && last_n < 20) begin
      last_n++;
      @(negedge clk);
    end
    chk(last_n == 8, "R4 no requeue", 64'(last_n), 64'd8);
    chk(io_rd == k, "R4 io write ignored", io_rd, k);
    chk(tbl_init, "R4 cmd ignored", 64'(tbl_init), 64'd1);
    @(negedge clk);
    chk(!busy, "R4 idle after", 64'(busy), 64'd0);

    // R10 delete
    check_key(pat(4), 1'b1, "R10 pre hit");
    run(OP_DELETE);
    chk(match_ok, "R10 flag kept", 64'(match_ok), 64'd1);
    check_key(pat(4), 1'b0, "R10 deleted");
    check_key(pat(3), 1'b1, "R10 neighbour kept");
    set_key(pat(40));
    run(OP_INSERT);
    check_key(pat(40), 1'b1, "R9 reuse free slot");
    set_key(pat(41));
    run(OP_INSERT);
    check_key(pat(41), 1'b0, "R9 full again");

    // R11 delete while uninitialized does nothing
    set_key(64'd0);
    run(OP_SET_MASK);
    chk(!tbl_init, "R11 init dropped 2", 64'(tbl_init), 64'd0);
    set_key(pat(6));
    run(OP_DELETE);
    run(OP_INIT);
    check_key(pat(6), 1'b1, "R11 uninit delete ignored");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule